// File: doc/BRIEF.md
# Asynchronous HDLC Byte Framer

This block is a byte-level HDLC engine placed between a UART's byte stream and the host. On the way out, the host writes a complete frame body into a 16-entry transmit FIFO and marks the final byte. The engine then sends an opening flag and the body with reserved octets escaped. It appends a complemented CRC-16 frame check sequence, low byte first, and ends with a closing flag. Nothing goes to the line until the whole body is queued, so a frame never stalls halfway for lack of host data.

On the way in, the engine hunts for a flag octet (0x7E) and removes escapes (0x7D followed by the octet XOR 0x20). It filters on the first (address) byte and runs the CRC over every unescaped byte. The last two bytes of a frame can only be known to be the FCS once the closing flag arrives, so data bytes reach the receive FIFO two bytes late. When a frame ends, the engine can flush the two FCS bytes to the host, depending on a configuration bit. It always queues one status item that tells whether the frame is good, failed its CRC, was too short or was aborted. The host tells data items from status items by a separate tag bit.

Top module: `hdlc_byte_framer`

## Requirements
- R1: Every transmitted frame begins and ends with 0x7E on `ltx_data`, and no raw 0x7E appears between those two flags.
- R2: Any payload or FCS octet equal to 0x7E or 0x7D is sent as 0x7D followed by the octet XOR 0x20.
- R3: After the last payload byte the transmitter sends the FCS. The FCS is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, computed over the unescaped payload and complemented. The low byte goes first.
- R4: No byte of a frame, not even its opening flag, is offered until the host has written the entry with `htx_last`=1. Once the opening flag is offered, `ltx_valid` stays high through the closing flag, and `ltx_data` holds while `ltx_valid` is high and `ltx_ready` is low.
- R5: Each direction buffers 16 byte entries. `htx_ready` is low while the transmit FIFO holds 16 entries, and `lrx_ready` is low while the receive FIFO holds 16 entries.
- R6: Received bytes before the first 0x7E are ignored, and consecutive 0x7E octets produce no items.
- R7: A received 0x7D followed by x is taken as the data byte x XOR 0x20.
- R8: With `cfg_addr_chk`=1, a frame whose first byte is neither `cfg_addr` nor 0xFF produces no items at all. With `cfg_addr_chk`=0, every address is accepted.
- R9: Data items (`hrx_status`=0) come out in order. Each accepted frame of three or more bytes ends with one status item (`hrx_status`=1). Its data is 0x01 when the CRC over all frame bytes leaves 0xF0B8, and 0x02 otherwise.
- R10: With `cfg_fcs_pass`=1, the two received FCS bytes are delivered as data items, low byte first, just before the status item. With `cfg_fcs_pass`=0, they are dropped.
- R11: A frame of one or two bytes produces no data items and a status item of 0x04.
- R12: The sequence 0x7D 0x7E aborts a frame. Data already delivered stays delivered, the two held bytes are discarded, and a status item of 0x08 follows. That 0x7E also opens the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Station address to match |
| cfg_addr_chk | input | 1 | 1 enables address filtering |
| cfg_fcs_pass | input | 1 | 1 forwards the received FCS bytes to the host |
| htx_data | input | 8 | Host transmit byte |
| htx_last | input | 1 | Marks the final byte of a frame body |
| htx_valid | input | 1 | Host transmit byte valid |
| htx_ready | output | 1 | Transmit FIFO can accept a byte |
| ltx_data | output | 8 | Byte to the UART transmitter |
| ltx_valid | output | 1 | Line transmit byte valid |
| ltx_ready | input | 1 | UART transmitter takes the byte |
| lrx_data | input | 8 | Byte from the UART receiver |
| lrx_valid | input | 1 | Line receive byte valid |
| lrx_ready | output | 1 | Engine takes the received byte |
| hrx_data | output | 8 | Received data byte or status code |
| hrx_status | output | 1 | 1 when the item is an end-of-frame status |
| hrx_valid | output | 1 | Receive item valid |
| hrx_ready | input | 1 | Host takes the receive item |

## Verification
The bench puts escapable octets into both directions and stalls the line side, to catch a transmitter that sends raw reserved octets or changes its output under backpressure. On the receive side it targets the two-byte holdback. An abort or a short frame must drop exactly the held bytes: a design that flushed them would deliver extra data, and one with no holdback would deliver the FCS even when stripping is selected. Frames with a foreign address, a broadcast address and a corrupted FCS check the filter and the residue test. The bench also fills both FIFOs, holding the line and the host back, to check that the ready signals drop at sixteen entries and no entry is lost.

// File: rtl/hdlc_pkg.sv
package hdlc_pkg;
  localparam logic [7:0]  FLAG_OCT  = 8'h7E;
  localparam logic [7:0]  ESC_OCT   = 8'h7D;
  localparam logic [7:0]  ESC_MASK  = 8'h20;
  localparam logic [7:0]  BCAST_ADR = 8'hFF;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  // end-of-frame status codes
  localparam logic [7:0]  ST_GOOD  = 8'h01;
  localparam logic [7:0]  ST_CRC   = 8'h02;
  localparam logic [7:0]  ST_SHORT = 8'h04;
  localparam logic [7:0]  ST_ABORT = 8'h08;
  localparam int          ITEM_W   = 9;

  // one byte through the reflected CRC-16
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

  function automatic logic is_reserved(input logic [7:0] b);
    return (b == FLAG_OCT) || (b == ESC_OCT);
  endfunction
endpackage

// File: rtl/hdlc_fifo.sv
module hdlc_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  a_r5_no_overflow:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r5_count_bound:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine import hdlc_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_queued,
  input  logic              q_empty,
  input  logic [ITEM_W-1:0] q_head,
  output logic              q_pop,
  output logic [7:0]        ltx_data,
  output logic              ltx_valid,
  input  logic              ltx_ready
);
  localparam int PW = $clog2(DEPTH + 1);
  typedef enum logic [2:0] {T_IDLE, T_OPEN, T_BODY, T_ESC2, T_CLOSE} tx_st_t;

  tx_st_t        st;
  logic          in_fcs, fidx;
  logic [15:0]   crc;
  logic [PW-1:0] pending;
  logic [7:0]    src;
  logic          fire, byte_done, last_out, esc_prev;

  assign src = in_fcs ? (fidx ? ~crc[15:8] : ~crc[7:0]) : q_head[7:0];

  always_comb begin
    ltx_valid = 1'b1;
    ltx_data  = FLAG_OCT;
    case (st)
      T_IDLE:  begin ltx_valid = 1'b0; ltx_data = 8'h00; end
      T_BODY:  ltx_data = is_reserved(src) ? ESC_OCT : src;
      T_ESC2:  ltx_data = src ^ ESC_MASK;
      default: ltx_data = FLAG_OCT;
    endcase
  end

  assign fire      = ltx_valid && ltx_ready;
  assign byte_done = fire && ((st == T_BODY && !is_reserved(src)) || st == T_ESC2);
  assign q_pop     = byte_done && !in_fcs;
  assign last_out  = q_pop && q_head[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; in_fcs <= 1'b0; fidx <= 1'b0; crc <= CRC_PRESET;
      pending <= '0; esc_prev <= 1'b0;
    end else begin
      pending <= pending + PW'(frame_queued) - PW'(last_out);
      if (fire) esc_prev <= (ltx_data == ESC_OCT);
      case (st)
        T_IDLE: if (pending != '0) st <= T_OPEN;
        T_OPEN: if (fire) begin
          st <= T_BODY; crc <= CRC_PRESET; in_fcs <= 1'b0; fidx <= 1'b0;
        end
        T_BODY, T_ESC2: begin
          if (fire && st == T_BODY && is_reserved(src)) st <= T_ESC2;
          if (byte_done) begin
            st <= T_BODY;
            if (!in_fcs) begin
              crc <= crc_step(crc, src);
              if (q_head[8]) in_fcs <= 1'b1;
            end else if (!fidx) fidx <= 1'b1;
            else st <= T_CLOSE;
          end
        end
        T_CLOSE: if (fire) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  // R4: body bytes are always present once a frame has started
  a_r4_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == T_BODY || st == T_ESC2) && !in_fcs) |-> !q_empty);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ltx_valid && !ltx_ready) |=> (ltx_valid && $stable(ltx_data)));
  // R2: an escape octet on the line is followed by an escaped reserved value
  a_r2_esc_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && esc_prev) |-> (ltx_data == 8'h5E || ltx_data == 8'h5D));
endmodule

// File: rtl/hdlc_rx_engine.sv
module hdlc_rx_engine import hdlc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_addr_chk,
  input  logic              cfg_fcs_pass,
  input  logic [7:0]        lrx_data,
  input  logic              lrx_valid,
  output logic              lrx_ready,
  output logic              q_push,
  output logic [ITEM_W-1:0] q_din,
  input  logic              q_full
);
  typedef enum logic [1:0] {R_HUNT, R_FRAME, R_DROP} rx_mode_t;
  typedef enum logic [1:0] {F_NONE, F_LO, F_HI, F_ST} flush_t;

  rx_mode_t    mode;
  flush_t      fl;
  logic        esc;
  logic [1:0]  len;            // saturates at 3 (three or more bytes)
  logic [7:0]  h0, h1, status;
  logic [15:0] crc;

  logic       fire, is_flag, esc_start, in_data, addr_ok, shift_out, frame_end;
  logic [7:0] dbyte;

  assign lrx_ready = (fl == F_NONE) && !q_full;
  assign fire      = lrx_valid && lrx_ready;
  assign is_flag   = (lrx_data == FLAG_OCT);
  assign esc_start = (lrx_data == ESC_OCT) && !esc;
  assign dbyte     = esc ? (lrx_data ^ ESC_MASK) : lrx_data;
  assign in_data   = fire && mode == R_FRAME && !is_flag && !esc_start;
  assign addr_ok   = !cfg_addr_chk || dbyte == cfg_addr || dbyte == BCAST_ADR;
  assign shift_out = in_data && len >= 2'd2;
  assign frame_end = fire && is_flag && mode == R_FRAME && (esc || len != 2'd0);

  always_comb begin
    q_push = 1'b0;
    q_din  = {1'b0, h0};
    case (fl)
      F_LO:    q_push = !q_full;
      F_HI:    begin q_push = !q_full; q_din = {1'b0, h1}; end
      F_ST:    begin q_push = !q_full; q_din = {1'b1, status}; end
      default: q_push = shift_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= R_HUNT; fl <= F_NONE; esc <= 1'b0; len <= 2'd0;
      h0 <= 8'h00; h1 <= 8'h00; status <= 8'h00; crc <= CRC_PRESET;
    end else begin
      if (fire) begin
        if (is_flag) begin
          mode <= R_FRAME; esc <= 1'b0; len <= 2'd0; crc <= CRC_PRESET;
          if (frame_end) begin
            status <= esc ? ST_ABORT : (len != 2'd3) ? ST_SHORT :
                      (crc == CRC_RESIDUE) ? ST_GOOD : ST_CRC;
            fl <= (!esc && len == 2'd3 && cfg_fcs_pass) ? F_LO : F_ST;
          end
        end else if (mode == R_FRAME) begin
          if (esc_start) esc <= 1'b1;
          else begin
            esc <= 1'b0;
            crc <= crc_step(crc, dbyte);
            h0  <= h1;
            h1  <= dbyte;
            if (len != 2'd3) len <= len + 2'd1;
            if (len == 2'd0 && !addr_ok) mode <= R_DROP;
          end
        end
      end else if (fl != F_NONE && !q_full) begin
        case (fl)
          F_LO:    fl <= F_HI;
          F_HI:    fl <= F_ST;
          default: fl <= F_NONE;
        endcase
      end
    end
  end

  a_r5_no_write_full: assert property (@(posedge clk) disable iff (!rst_n) q_push |-> !q_full);
  a_r10_flush_stall:  assert property (@(posedge clk) disable iff (!rst_n) (fl != F_NONE) |-> !lrx_ready);
  a_r6_hunt_silent:   assert property (@(posedge clk) disable iff (!rst_n) (mode == R_HUNT) |-> !q_push);
  a_r9_end_flush:     assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> (fl != F_NONE));
endmodule

// File: rtl/hdlc_byte_framer.sv
module hdlc_byte_framer import hdlc_pkg::*; #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_addr,
  input  logic       cfg_addr_chk,
  input  logic       cfg_fcs_pass,
  input  logic [7:0] htx_data,
  input  logic       htx_last,
  input  logic       htx_valid,
  output logic       htx_ready,
  output logic [7:0] ltx_data,
  output logic       ltx_valid,
  input  logic       ltx_ready,
  input  logic [7:0] lrx_data,
  input  logic       lrx_valid,
  output logic       lrx_ready,
  output logic [7:0] hrx_data,
  output logic       hrx_status,
  output logic       hrx_valid,
  input  logic       hrx_ready
);
  logic              tx_full, tx_empty, tx_pop, tx_push;
  logic [ITEM_W-1:0] tx_head;
  logic              rx_full, rx_empty, rx_push;
  logic [ITEM_W-1:0] rx_din, rx_dout;

  assign htx_ready = !tx_full;
  assign tx_push   = htx_valid && !tx_full;

  hdlc_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din({htx_last, htx_data}), .full(tx_full),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty));

  hdlc_tx_engine #(.DEPTH(FIFO_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_queued(tx_push && htx_last), .q_empty(tx_empty),
    .q_head(tx_head), .q_pop(tx_pop), .ltx_data(ltx_data), .ltx_valid(ltx_valid),
    .ltx_ready(ltx_ready));

  hdlc_rx_engine u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_addr_chk(cfg_addr_chk),
    .cfg_fcs_pass(cfg_fcs_pass), .lrx_data(lrx_data), .lrx_valid(lrx_valid),
    .lrx_ready(lrx_ready), .q_push(rx_push), .q_din(rx_din), .q_full(rx_full));

  hdlc_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .full(rx_full),
    .pop(hrx_valid && hrx_ready), .dout(rx_dout), .empty(rx_empty));

  assign hrx_valid  = !rx_empty;
  assign hrx_status = rx_dout[8];
  assign hrx_data   = rx_dout[7:0];
endmodule

// File: tb/tb_hdlc_byte_framer.sv
module tb_hdlc_byte_framer;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cfg_addr_chk, cfg_fcs_pass;
  logic [7:0] cfg_addr;
  logic [7:0] htx_data;  logic htx_last, htx_valid, htx_ready;
  logic [7:0] ltx_data;  logic ltx_valid, ltx_ready;
  logic [7:0] lrx_data;  logic lrx_valid, lrx_ready;
  logic [7:0] hrx_data;  logic hrx_status, hrx_valid, hrx_ready;

  hdlc_byte_framer dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_tx[$];
  logic [8:0] exp_rx[$];
  bit tx_stall = 0, rx_hold = 0, in_frm = 0, gap = 0;
  int tx_cyc = 0, rx_cyc = 0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // bit-serial reference: returns the complemented FCS as sent on the line
  function automatic logic [15:0] ref_fcs(input bq_t b);
    logic [15:0] c = 16'hFFFF;
    foreach (b[k]) for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[k][i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return ~c;
  endfunction

  function automatic void exp_tx_byte(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin exp_tx.push_back(8'h7D); exp_tx.push_back(b ^ 8'h20); end
    else exp_tx.push_back(b);
  endfunction

  // ---------------- transmit driver ----------------
  task automatic send_tx(input bq_t body, input bit slow);
    logic [15:0] f;
    f = ref_fcs(body);
    exp_tx.push_back(8'h7E);
    foreach (body[i]) exp_tx_byte(body[i]);
    exp_tx_byte(f[7:0]);
    exp_tx_byte(f[15:8]);
    exp_tx.push_back(8'h7E);
    foreach (body[i]) begin
      @(negedge clk);
      htx_data = body[i]; htx_last = (i == body.size() - 1); htx_valid = 1'b1;
      while (!htx_ready) @(negedge clk);
      @(posedge clk);
      if (slow && i != body.size() - 1) begin
        @(negedge clk); htx_valid = 1'b0;
        repeat (3) begin
          @(negedge clk);
          check(!ltx_valid, "R4 nothing sent before last byte", 16'(ltx_valid), 16'h0);
        end
      end
    end
    @(negedge clk); htx_valid = 1'b0; htx_last = 1'b0;
  endtask

  // ---------------- transmit monitor ----------------
  always @(negedge clk) begin
    tx_cyc++;
    ltx_ready = !tx_stall && (tx_cyc % 4 != 3);
    if (rst_n && in_frm && !ltx_valid) gap = 1;
    if (rst_n && ltx_valid && ltx_ready) begin
      if (exp_tx.size() == 0) check(0, "R1 unexpected line byte", 16'(ltx_data), 16'hFFFF);
      else begin
        logic [7:0] e;
        e = exp_tx.pop_front();
        check(ltx_data == e, "R1 R2 R3 line byte", 16'(ltx_data), 16'(e));
      end
      if (ltx_data == 8'h7E) begin
        if (in_frm) check(!gap, "R4 no gap inside frame", 16'(gap), 16'h0);
        in_frm = !in_frm; gap = 0;
      end
    end
  end

  // ---------------- receive driver ----------------
  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    lrx_data = b; lrx_valid = 1'b1;
    while (!lrx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); lrx_valid = 1'b0;
  endtask

  task automatic rx_esc(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin rx_byte(8'h7D); rx_byte(b ^ 8'h20); end
    else rx_byte(b);
  endtask

  // sends body + FCS + closing flag (the opening flag comes from the previous close)
  task automatic rx_frame(input bq_t body, input logic [15:0] fcs_xor);
    logic [15:0] f;
    f = ref_fcs(body) ^ fcs_xor;
    foreach (body[i]) rx_esc(body[i]);
    rx_esc(f[7:0]); rx_esc(f[15:8]);
    rx_byte(8'h7E);
  endtask

  function automatic void exp_frame(input bq_t body, input logic [15:0] fcs_xor,
                                    input bit pass, input logic [7:0] st);
    logic [15:0] f;
    f = ref_fcs(body) ^ fcs_xor;
    foreach (body[i]) exp_rx.push_back({1'b0, body[i]});
    if (pass) begin exp_rx.push_back({1'b0, f[7:0]}); exp_rx.push_back({1'b0, f[15:8]}); end
    exp_rx.push_back({1'b1, st});
  endfunction

  // ---------------- receive monitor ----------------
  always @(negedge clk) begin
    rx_cyc++;
    hrx_ready = !rx_hold && (rx_cyc % 3 != 1);
    if (rst_n && hrx_valid && hrx_ready) begin
      if (exp_rx.size() == 0) check(0, "R8 unexpected receive item", {7'h0, hrx_status, hrx_data}, 16'hFFFF);
      else begin
        logic [8:0] e;
        e = exp_rx.pop_front();
        check({hrx_status, hrx_data} == e, "R9 R10 receive item", {7'h0, hrx_status, hrx_data}, {7'h0, e});
      end
    end
  end

  task automatic drain(input string req);
    int t = 0;
    while ((exp_tx.size() != 0 || exp_rx.size() != 0) && t < 5000) begin @(negedge clk); t++; end
    check(exp_tx.size() == 0 && exp_rx.size() == 0, req, 16'(exp_tx.size() + exp_rx.size()), 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog expired: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bq_t big, part;
    rst_n = 0; cfg_addr = 8'h42; cfg_addr_chk = 1; cfg_fcs_pass = 0;
    htx_data = 0; htx_last = 0; htx_valid = 0; lrx_data = 0; lrx_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(htx_ready, "R5 reset tx fifo empty", 16'(htx_ready), 16'h1);
    check(!ltx_valid, "R1 reset line idle", 16'(ltx_valid), 16'h0);
    check(!hrx_valid, "R9 reset no receive item", 16'(hrx_valid), 16'h0);
    check(lrx_ready, "R5 reset rx fifo empty", 16'(lrx_ready), 16'h1);

    // ---- transmit ----
    send_tx('{8'h01, 8'h02, 8'h03}, 1);                 // R4 whole frame first
    send_tx('{8'h7E, 8'h11, 8'h7D, 8'h22, 8'h5E}, 0);   // R2 escapes
    drain("R3 tx frames complete");
    tx_stall = 1;                                       // R5 fill all 16 entries
    big = {};
    for (int i = 0; i < 16; i++) big.push_back(8'(8'h30 + i * 7));
    send_tx(big, 0);
    @(negedge clk);
    check(!htx_ready, "R5 tx fifo full at 16", 16'(htx_ready), 16'h0);
    tx_stall = 0;
    drain("R5 tx full frame sent");

    // ---- receive ----
    rx_byte(8'h11); rx_byte(8'h22);                     // R6 hunt: ignored
    rx_byte(8'h7E); rx_byte(8'h7E); rx_byte(8'h7E);     // R6 idle flags
    exp_frame('{8'h42, 8'h7E, 8'h10, 8'h7D, 8'h20}, 16'h0, 0, 8'h01);  // R7
    rx_frame('{8'h42, 8'h7E, 8'h10, 8'h7D, 8'h20}, 16'h0);
    drain("R7 unescaped frame");
    cfg_fcs_pass = 1;                                   // R10 forward FCS
    exp_frame('{8'h42, 8'h55}, 16'h0, 1, 8'h01);
    rx_frame('{8'h42, 8'h55}, 16'h0);
    drain("R10 fcs forwarded");
    cfg_fcs_pass = 0;
    rx_frame('{8'h43, 8'h01, 8'h02}, 16'h0);            // R8 foreign address dropped
    exp_frame('{8'hFF, 8'h09}, 16'h0, 0, 8'h01);        // R8 broadcast accepted
    rx_frame('{8'hFF, 8'h09}, 16'h0);
    drain("R8 filter and broadcast");
    cfg_addr_chk = 0;
    exp_frame('{8'h43, 8'h07}, 16'h0, 0, 8'h01);        // R8 filter off
    rx_frame('{8'h43, 8'h07}, 16'h0);
    drain("R8 promiscuous");
    cfg_addr_chk = 1;
    exp_frame('{8'h42, 8'h01, 8'h02, 8'h03}, 16'h0001, 0, 8'h02);  // R9 bad CRC
    rx_frame('{8'h42, 8'h01, 8'h02, 8'h03}, 16'h0001);
    drain("R9 crc error status");
    exp_rx.push_back({1'b1, 8'h04});                    // R11 one byte
    rx_byte(8'h42); rx_byte(8'h7E);
    exp_rx.push_back({1'b1, 8'h04});                    // R11 two bytes
    rx_byte(8'h42); rx_byte(8'h05); rx_byte(8'h7E);
    drain("R11 short frames");
    exp_rx.push_back({1'b0, 8'h42}); exp_rx.push_back({1'b0, 8'h01});
    exp_rx.push_back({1'b1, 8'h08});                    // R12 abort
    rx_byte(8'h42); rx_byte(8'h01); rx_byte(8'h02); rx_byte(8'h03);
    rx_byte(8'h7D); rx_byte(8'h7E);
    exp_frame('{8'h42, 8'h66}, 16'h0, 0, 8'h01);        // R12 flag opened next frame
    rx_frame('{8'h42, 8'h66}, 16'h0);
    drain("R12 abort and reopen");

    // R5 receive FIFO fills at 16 entries
    big = {8'h42};
    for (int i = 0; i < 20; i++) big.push_back(8'(8'h10 + i));
    exp_frame(big, 16'h0, 0, 8'h01);
    rx_hold = 1;
    for (int i = 0; i < 18; i++) rx_byte(big[i]);
    @(negedge clk);
    check(!lrx_ready, "R5 rx fifo full at 16", 16'(lrx_ready), 16'h0);
    rx_hold = 0;
    part = {};
    for (int i = 18; i < 21; i++) part.push_back(big[i]);
    begin
      logic [15:0] f;
      f = ref_fcs(big);
      foreach (part[i]) rx_esc(part[i]);
      rx_esc(f[7:0]); rx_esc(f[15:8]); rx_byte(8'h7E);
    end
    drain("R5 rx full frame delivered");

    repeat (10) @(negedge clk);
    check(!hrx_valid, "R8 no stray items", 16'(hrx_valid), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule